// File: doc/BRIEF.md
# I2S Audio Transmitter

This block is the transmit side of an I2S serial audio port. Software writes control values, divider settings and 32-bit sample words through a small write-only register port. Sample words are held in an eight-entry FIFO and are shifted out on a serial data line. The line is framed by a word-select signal and timed by a bit clock. At run time the block can send 8-, 16- or 32-bit samples, in stereo or in mono.

All logic runs on the peripheral clock `clk`. A master clock is made by toggling `mclk_o` once every N peripheral cycles. The bit clock is made by toggling `bclk_o` once every M master-clock toggles, where N and M are programmable. The serialiser moves only on the cycles where the bit clock falls, so `mclk_o` and `bclk_o` are registered outputs and no second clock domain exists. The FIFO fill level and a sticky underflow flag are brought out as status pins.

Register map (`reg_addr`): 0 = control, with bits [1:0] the width code and bit 2 the mono select. 1 = push one sample word into the FIFO. 2 = master divider N in bits [7:0]. 3 = bit-clock divider M in bits [7:0]. 4 = status, where writing bit 0 as 1 clears the underflow flag.

Top module: `i2s_tx_core`

## Requirements
- R1: After synchronous reset, `bclk_o`, `ws_o`, `sd_o`, `mclk_o` and `underflow_o` are 0 and `fifo_level` is 0. The configuration is 32-bit stereo, so a stream started without a control write sends 32-bit stereo frames.
- R2: The FIFO holds 8 words of 32 bits. `fifo_level` reports the count of words held. A push while 8 words are held is dropped, and the dropped word is never transmitted.
- R3: Width code 0 sends 8-bit samples, code 1 sends 16-bit samples and code 3 sends 32-bit samples. Each sample is taken from the low bits of its FIFO word, and the higher bits are ignored.
- R4: Width code 2 is reserved and is handled as 32-bit samples.
- R5: Data is sent MSB first and changes only when `bclk_o` falls. `ws_o` is 0 for the left channel and 1 for the right channel. `ws_o` switches on the last bit of each word, one bit clock before the next word's MSB.
- R6: In stereo mode (mono bit 0), consecutive FIFO words are sent alternately on the left and right channels, starting with left.
- R7: In mono mode (mono bit 1), each FIFO word is sent on the left channel and then again on the right channel.
- R8: A word slot that finds the FIFO empty is sent as all zeros and sets `underflow_o`. The flag stays set until a status write with bit 0 = 1. A status write with bit 0 = 0 leaves the flag set.
- R9: `mclk_o` toggles every N `clk` cycles and `bclk_o` toggles every M `mclk_o` toggles, so the bit-clock period is 2·N·M `clk` cycles.
- R10: While N or M is 0, `mclk_o`, `bclk_o`, `ws_o` and `sd_o` stay at 0 and no word leaves the FIFO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| mclk_o | output | 1 | Master clock output |
| bclk_o | output | 1 | Serial bit clock |
| ws_o | output | 1 | Word select (0 = left, 1 = right) |
| sd_o | output | 1 | Serial data |
| fifo_level | output | 4 | Words currently held in the FIFO |
| underflow_o | output | 1 | Sticky underflow flag |

## Verification
The hardest case to reach is a FIFO that fills to its limit, drops further pushes, and then drains into underflow while the stream is running. The bench reaches it by pushing ten words while both dividers are 0, so nothing is consumed. It checks that the level stops at eight, then starts the bit clock and decodes ten word slots. Eight slots must carry the accepted words and the last two must carry zeros. To check that the flag is sticky, the bit clock is stopped first so that no new empty slot can set the flag again, and only then are the two status writes made.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SAMPLE_W = 32;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_DATA  = 3'd1;
  localparam logic [2:0] ADDR_MDIV  = 3'd2;
  localparam logic [2:0] ADDR_BDIV  = 3'd3;
  localparam logic [2:0] ADDR_STAT  = 3'd4;

  typedef struct packed {
    logic       mono;
    logic [1:0] wcode;
  } tx_cfg_t;

  // Reserved code 2 falls into the 32-bit case.
  function automatic logic [5:0] width_bits(input logic [1:0] code);
    case (code)
      2'd0:    width_bits = 6'd8;
      2'd1:    width_bits = 6'd16;
      default: width_bits = 6'd32;
    endcase
  endfunction

endpackage

// File: rtl/i2s_tx_fifo.sv
module i2s_tx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     push,
  input  logic [WIDTH-1:0]         wdata,
  input  logic                     pop,
  output logic [WIDTH-1:0]         rdata,
  output logic                     empty,
  output logic                     full,
  output logic [$clog2(DEPTH):0]   level
);

  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [AW:0]      cnt;
  logic             do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == (AW+1)'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp];
  assign level   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH-1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH-1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  // R2
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full);

endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIVW-1:0] mdiv,
  input  logic [DIVW-1:0] bdiv,
  output logic            run,
  output logic            mclk_o,
  output logic            bclk_o,
  output logic            bfall
);

  logic [DIVW-1:0] mcnt, bcnt;
  logic            mtick, bterm;

  assign run   = (mdiv != '0) && (bdiv != '0);
  assign mtick = run && (mcnt == mdiv - DIVW'(1));
  assign bterm = (bcnt == bdiv - DIVW'(1));
  assign bfall = mtick && bterm && bclk_o;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      mcnt   <= '0;
      bcnt   <= '0;
      mclk_o <= 1'b0;
      bclk_o <= 1'b0;
    end else if (mtick) begin
      mcnt   <= '0;
      mclk_o <= ~mclk_o;
      if (bterm) begin
        bcnt   <= '0;
        bclk_o <= ~bclk_o;
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end else begin
      mcnt <= mcnt + 1'b1;
    end
  end

  // R10
  bclk_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!bclk_o && !mclk_o));

  // R9
  bclk_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !mtick) |=> $stable(bclk_o));

endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          bfall,
  input  tx_cfg_t       cfg,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          pop,
  output logic          urun,
  output logic          sd_o,
  output logic          ws_o
);

  logic [5:0]    cnt, cur_w, wbits;
  logic          chan, cur_mono, mono_eff;
  logic          frame_start, need_new, last;
  logic [DW-1:0] sh, hold, word, aligned;
  logic [6:0]    shamt;

  assign frame_start = (cnt == '0) && !chan;
  assign wbits       = frame_start ? width_bits(cfg.wcode) : cur_w;
  assign mono_eff    = frame_start ? cfg.mono : cur_mono;
  assign need_new    = (cnt == '0) && (!chan || !mono_eff);
  assign last        = (cnt == wbits - 6'd1);
  assign pop         = bfall && need_new && !fifo_empty;
  assign urun        = bfall && need_new && fifo_empty;
  assign word        = need_new ? (fifo_empty ? '0 : fifo_rdata) : hold;
  assign shamt       = 7'(DW) - {1'b0, wbits};
  assign aligned     = word << shamt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt      <= '0;
      chan     <= 1'b0;
      sh       <= '0;
      hold     <= '0;
      cur_w    <= 6'd32;
      cur_mono <= 1'b0;
      sd_o     <= 1'b0;
      ws_o     <= 1'b0;
    end else if (bfall) begin
      if (cnt == '0) begin
        sd_o <= aligned[DW-1];
        sh   <= aligned << 1;
        if (need_new)    hold <= word;
        if (frame_start) begin
          cur_w    <= wbits;
          cur_mono <= cfg.mono;
        end
      end else begin
        sd_o <= sh[DW-1];
        sh   <= sh << 1;
      end
      ws_o <= last ? ~chan : chan;
      cnt  <= last ? '0 : cnt + 1'b1;
      if (last) chan <= ~chan;
    end
  end

  // R5
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bfall) |=> $stable(sd_o));

  // R5
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !bfall) |=> $stable(ws_o));

  // R8
  urun_nopop_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && urun));

endmodule

// File: rtl/i2s_tx_core.sv
module i2s_tx_core
  import i2s_tx_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIVW  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_wr,
  input  logic [2:0]             reg_addr,
  input  logic [31:0]            reg_wdata,
  output logic                   mclk_o,
  output logic                   bclk_o,
  output logic                   ws_o,
  output logic                   sd_o,
  output logic [$clog2(DEPTH):0] fifo_level,
  output logic                   underflow_o
);

  tx_cfg_t             cfg;
  logic [DIVW-1:0]     mdiv, bdiv;
  logic                push, clr, run, bfall, pop, urun, empty, full;
  logic [SAMPLE_W-1:0] rdata;

  assign push = reg_wr && (reg_addr == ADDR_DATA);
  assign clr  = reg_wr && (reg_addr == ADDR_STAT) && reg_wdata[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg         <= '{mono: 1'b0, wcode: 2'd3};
      mdiv        <= '0;
      bdiv        <= '0;
      underflow_o <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == ADDR_CTRL) cfg  <= tx_cfg_t'(reg_wdata[2:0]);
      if (reg_wr && reg_addr == ADDR_MDIV) mdiv <= reg_wdata[DIVW-1:0];
      if (reg_wr && reg_addr == ADDR_BDIV) bdiv <= reg_wdata[DIVW-1:0];
      if (urun)     underflow_o <= 1'b1;
      else if (clr) underflow_o <= 1'b0;
    end
  end

  i2s_tx_fifo #(.DEPTH(DEPTH), .WIDTH(SAMPLE_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(reg_wdata), .pop(pop),
    .rdata(rdata), .empty(empty), .full(full), .level(fifo_level)
  );

  i2s_tx_clkgen #(.DIVW(DIVW)) u_clk (
    .clk(clk), .rst(rst), .mdiv(mdiv), .bdiv(bdiv), .run(run),
    .mclk_o(mclk_o), .bclk_o(bclk_o), .bfall(bfall)
  );

  i2s_tx_serializer #(.DW(SAMPLE_W)) u_ser (
    .clk(clk), .rst(rst), .run(run), .bfall(bfall), .cfg(cfg),
    .fifo_empty(empty), .fifo_rdata(rdata), .pop(pop), .urun(urun),
    .sd_o(sd_o), .ws_o(ws_o)
  );

  // R8
  urun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow_o && !clr) |=> underflow_o);

  // R10
  idle_nopop_chk: assert property (@(posedge clk) disable iff (rst)
    !run |-> !pop);

endmodule

// File: tb/tb_i2s_tx_core.sv
module tb_i2s_tx_core;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        mclk_o, bclk_o, ws_o, sd_o, underflow_o;
  logic [3:0]  fifo_level;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  logic [31:0] wq [0:15];
  logic        sd_cap [0:1023];
  logic        ws_cap [0:1023];

  always #4 clk = ~clk;

  i2s_tx_core dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mclk_o(mclk_o), .bclk_o(bclk_o), .ws_o(ws_o),
    .sd_o(sd_o), .fifo_level(fifo_level), .underflow_o(underflow_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic push_n(input int n);
    for (int i = 0; i < n; i++) wr(3'd1, wq[i]);
  endtask

  // Records sd/ws at each bclk rising edge; the first rise precedes any data.
  task automatic capture(input int n);
    int   rises;
    logic pb;
    rises = 0;
    pb = bclk_o;
    while (rises < n + 1) begin
      @(negedge clk);
      if (bclk_o && !pb) begin
        if (rises > 0) begin
          sd_cap[rises-1] = sd_o;
          ws_cap[rises-1] = ws_o;
        end
        rises++;
      end
      pb = bclk_o;
    end
  endtask

  task automatic cmp_stream(input int nw, input int w, input bit mono,
                            input int nbits, input string req);
    int bad_sd, bad_ws;
    bad_sd = 0; bad_ws = 0;
    for (int b = 0; b < nbits; b++) begin
      int slot, bit_i, ch, wi;
      logic [31:0] word;
      logic esd, ews;
      slot  = b / w;
      bit_i = b % w;
      ch    = slot % 2;
      wi    = mono ? slot / 2 : slot;
      word  = (wi < nw) ? wq[wi] : 32'd0;
      esd   = word[w-1-bit_i];
      ews   = (bit_i == w - 1) ? ~ch[0] : ch[0];
      if (sd_cap[b] !== esd) bad_sd++;
      if (ws_cap[b] !== ews) bad_ws++;
    end
    chk(bad_sd == 0, req, "serial data bit mismatches", bad_sd, 0);
    chk(bad_ws == 0, "R5", "word select mismatches", bad_ws, 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk(fifo_level == 0, "R1", "level after reset", fifo_level, 0);
    chk(underflow_o == 0, "R1", "underflow after reset", underflow_o, 0);
    chk({bclk_o, ws_o, sd_o, mclk_o} == 4'b0, "R1", "serial lines after reset",
        {bclk_o, ws_o, sd_o, mclk_o}, 0);
  endtask

  task automatic t_default_stereo();
    do_reset();
    wq[0] = 32'hA5C3_0F81; wq[1] = 32'h1234_5678;
    wq[2] = 32'h8000_0001; wq[3] = 32'hFFFF_0000;
    push_n(4);
    chk(fifo_level == 4, "R2", "level after 4 pushes", fifo_level, 4);
    wr(3'd2, 1); wr(3'd3, 1);
    capture(128);
    cmp_stream(4, 32, 0, 128, "R1 R6");
  endtask

  task automatic t_w16_stereo();
    do_reset();
    wr(3'd0, 32'h1);
    wq[0] = 32'hDEAD_BEEF; wq[1] = 32'h5555_1234;
    wq[2] = 32'hFFFF_8001; wq[3] = 32'h0000_7FFE;
    push_n(4);
    wr(3'd2, 1); wr(3'd3, 1);
    capture(96);
    cmp_stream(4, 16, 0, 96, "R3 R6");
  endtask

  task automatic t_w8_mono();
    do_reset();
    wr(3'd0, 32'h4);
    wq[0] = 32'hFFFF_FF96; wq[1] = 32'h0000_003C; wq[2] = 32'h1234_56C1;
    push_n(3);
    wr(3'd2, 1); wr(3'd3, 1);
    capture(64);
    cmp_stream(3, 8, 1, 64, "R3 R7");
  endtask

  task automatic t_reserved();
    do_reset();
    wr(3'd0, 32'h2);
    wq[0] = 32'hC001_D00D; wq[1] = 32'h0BAD_F00D;
    push_n(2);
    wr(3'd2, 1); wr(3'd3, 1);
    capture(64);
    cmp_stream(2, 32, 0, 64, "R4");
  endtask

  task automatic t_full_underflow();
    do_reset();
    for (int i = 0; i < 10; i++) wq[i] = 32'h1000_0001 * (i + 3) ^ 32'h5A5A_A5A5;
    push_n(10);
    chk(fifo_level == 8, "R2", "level caps at 8", fifo_level, 8);
    chk(underflow_o == 0, "R8", "no underflow before start", underflow_o, 0);
    wr(3'd2, 1); wr(3'd3, 1);
    capture(320);
    cmp_stream(8, 32, 0, 320, "R2 R8");
    chk(underflow_o == 1, "R8", "underflow set after drain", underflow_o, 1);
    wr(3'd3, 0);
    repeat (4) @(negedge clk);
    wr(3'd4, 0);
    @(negedge clk);
    chk(underflow_o == 1, "R8", "flag held after write of 0", underflow_o, 1);
    wr(3'd4, 1);
    @(negedge clk);
    chk(underflow_o == 0, "R8", "flag cleared by write of 1", underflow_o, 0);
  endtask

  task automatic t_dividers();
    int   t_rise0, t_rise1, cyc, mhi, mprev;
    logic pb;
    do_reset();
    wr(3'd2, 3); wr(3'd3, 2);
    cyc = 0; t_rise0 = -1; t_rise1 = -1; mhi = 0; mprev = 0;
    pb = bclk_o;
    while (t_rise1 < 0 && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (bclk_o && !pb) begin
        if (t_rise0 < 0) t_rise0 = cyc; else t_rise1 = cyc;
      end
      pb = bclk_o;
      if (mclk_o) mhi++;
      else if (mhi > 0 && mprev == 0) mprev = mhi;
    end
    chk(t_rise1 - t_rise0 == 12, "R9", "bclk period in clk cycles",
        t_rise1 - t_rise0, 12);
    chk(mprev == 3, "R9", "mclk high time in clk cycles", mprev, 3);
  endtask

  task automatic t_idle();
    int seen;
    do_reset();
    wq[0] = 32'hFFFF_FFFF; wq[1] = 32'hFFFF_FFFF;
    push_n(2);
    wr(3'd2, 2);
    seen = 0;
    repeat (40) begin
      @(negedge clk);
      if (bclk_o || ws_o || sd_o || mclk_o) seen++;
    end
    chk(seen == 0, "R10", "activity with bit divider 0", seen, 0);
    wr(3'd2, 0); wr(3'd3, 1);
    repeat (40) begin
      @(negedge clk);
      if (bclk_o || ws_o || sd_o || mclk_o) seen++;
    end
    chk(seen == 0, "R10", "activity with master divider 0", seen, 0);
    chk(fifo_level == 2, "R10", "no words consumed while idle", fifo_level, 2);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_default_stereo();
    t_w16_stereo();
    t_w8_mono();
    t_reserved();
    t_full_underflow();
    t_dividers();
    t_idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule